// File: doc/BRIEF.md
# Sixteen-Line Interrupt Controller with Per-Channel Polarity and Edge Selection

This block gathers sixteen asynchronous interrupt source lines and turns them into two processor request lines, a normal request and a fast request. Every line first crosses into the clock domain through a two-stage synchroniser. How a line is then interpreted depends on its channel. Channels 0 to 5 each choose their active polarity and choose between level and edge sensing. Channels 6 to 8 choose only their polarity and are always level sensitive. Channels 9 to 15 are fixed as active-high level inputs.

An edge-sensed channel remembers an active transition in a latch until software writes a one to that channel's bit in the clear register. A level-sensed channel reports its synchronised input at its active polarity and is not affected by the clear register. The raw pending word can be read no matter how the enables are set. Two separate enable words gate it into the normal-request status and the fast-request status. Each output line is raised while its status is nonzero. A priority encoder reports the lowest-numbered active normal request together with a valid flag.

Software reaches the block through a simple port: a write strobe, a 3-bit address and 16-bit write data. Read data is combinational and reflects the current address.

Top module: `pol_edge_intc`

## Requirements
- R1: Synchronous reset clears both configuration words, both enable words, all edge latches and the synchroniser stages. Directly after reset, both request lines, the vector valid flag and the vector are 0.
- R2: A level-sensed channel's raw pending bit equals its input at active polarity, delayed by the two synchroniser flops. It appears in the second cycle after the input changes. A clear write leaves it unchanged.
- R3: An edge-sensed channel sets its pending bit on an active transition of its synchronised input: rising when the polarity bit is 1, falling when it is 0. The bit shows three cycles after the input change and stays set after the input returns.
- R4: Writing to the clear register (address 2) clears each edge latch whose data bit is 1 and leaves latches with a 0 bit untouched. If a new active transition arrives in the same cycle, the latch stays set.
- R5: Configuration word A (address 0) holds channel i's polarity (1 = active high) at bit 2i and its edge select (1 = edge) at bit 2i+1, for i = 0..5. Bits 12 to 15 read as 0.
- R6: Configuration word B (address 1) holds the polarity of channels 6, 7 and 8 at bits 0, 1 and 2. Bits above 2 read as 0. Channels 6 to 15 are always level sensed, and channels 9 to 15 are always active high.
- R7: Normal status (address 6) is raw pending ANDed with the normal enable word (address 3). Fast status (address 7) is raw pending ANDed with the fast enable word (address 4). Raw pending (address 5) reads the same whatever the enables hold.
- R8: The normal request line is high exactly when normal status is nonzero. The fast request line is high exactly when fast status is nonzero.
- R9: The vector output is the index of the lowest set bit of normal status, searched over all 16 positions. The valid flag is high exactly when normal status is nonzero. The vector is 0 when the flag is low.
- R10: Read data is combinational for the addressed register. The clear register reads as 0. Writes to addresses 2, 5, 6 and 7 change no readable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_in | input | 16 | Asynchronous interrupt source lines |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| irq_vec | output | 4 | Lowest active normal request number |
| irq_vec_valid | output | 1 | Vector is meaningful |

## Verification
The checker confirms on every cycle that each request line agrees with raw pending gated by its enable word. It also confirms that the vector flag tracks the normal line, and that the reported vector is an enabled pending channel with no lower one active. The quiet state just after reset is checked the same way. The bench scenarios are what show the timing of the synchroniser and the edge latch, the choice of active transition, the rule that a set beats a clear in the same cycle, and that level channels ignore clears. They also cover the register field layout and the writes that must be ignored, all compared against a cycle model driven by random and directed stimulus.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        REG_CFGA  = 3'd0,
        REG_CFGB  = 3'd1,
        REG_CLR   = 3'd2,
        REG_IEN   = 3'd3,
        REG_FEN   = 3'd4,
        REG_RAW   = 3'd5,
        REG_ISTAT = 3'd6,
        REG_FSTAT = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic pol_high;
        logic edge_sel;
    } chan_cfg_t;

    function automatic logic active_level(input logic pol_high, input logic v);
        return pol_high ? v : ~v;
    endfunction

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;
    logic [W-1:0] stage3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
            stage3_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
            stage3_q <= stage2_q;
        end
    end

    assign cur  = stage2_q;
    assign prev = stage3_q;
endmodule

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
#(
    parameter int NUM_SRC     = 16,
    parameter int NUM_EDGE    = 6,
    parameter int NUM_POLONLY = 3,
    parameter int DATA_W      = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [REG_AW-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [NUM_SRC-1:0]           raw,
    input  logic [NUM_SRC-1:0]           irq_stat,
    input  logic [NUM_SRC-1:0]           fiq_stat,
    output logic [DATA_W-1:0]            rdata,
    output chan_cfg_t [NUM_SRC-1:0]      chan_cfg,
    output logic [NUM_SRC-1:0]           clr_mask,
    output logic [NUM_SRC-1:0]           irq_en,
    output logic [NUM_SRC-1:0]           fiq_en
);
    localparam int CFGA_W = 2 * NUM_EDGE;
    localparam int CFGB_W = NUM_POLONLY;
    localparam logic [DATA_W-1:0] CFGA_MASK = DATA_W'((64'd1 << CFGA_W) - 64'd1);
    localparam logic [DATA_W-1:0] CFGB_MASK = DATA_W'((64'd1 << CFGB_W) - 64'd1);

    reg_sel_e sel;
    logic [DATA_W-1:0] cfga_q;
    logic [DATA_W-1:0] cfgb_q;

    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfga_q <= '0;
            cfgb_q <= '0;
            irq_en <= '0;
            fiq_en <= '0;
        end else if (wr_en) begin
            case (sel)
                REG_CFGA: cfga_q <= wdata & CFGA_MASK;
                REG_CFGB: cfgb_q <= wdata & CFGB_MASK;
                REG_IEN:  irq_en <= wdata[NUM_SRC-1:0];
                REG_FEN:  fiq_en <= wdata[NUM_SRC-1:0];
                default:  ;
            endcase
        end
    end

    assign clr_mask = (wr_en && sel == REG_CLR) ? wdata[NUM_SRC-1:0] : '0;

    // Per-channel configuration: three variants chosen by channel index
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cfg
        if (i < NUM_EDGE) begin : g_full
            assign chan_cfg[i].pol_high = cfga_q[2*i];
            assign chan_cfg[i].edge_sel = cfga_q[2*i+1];
        end else if (i < NUM_EDGE + NUM_POLONLY) begin : g_pol
            assign chan_cfg[i].pol_high = cfgb_q[i-NUM_EDGE];
            assign chan_cfg[i].edge_sel = 1'b0;
        end else begin : g_fixed
            assign chan_cfg[i].pol_high = 1'b1;
            assign chan_cfg[i].edge_sel = 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            REG_CFGA:  rdata = cfga_q;
            REG_CFGB:  rdata = cfgb_q;
            REG_CLR:   rdata = '0;
            REG_IEN:   rdata = DATA_W'(irq_en);
            REG_FEN:   rdata = DATA_W'(fiq_en);
            REG_RAW:   rdata = DATA_W'(raw);
            REG_ISTAT: rdata = DATA_W'(irq_stat);
            REG_FSTAT: rdata = DATA_W'(fiq_stat);
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/intc_pending.sv
module intc_pending
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_SRC-1:0]      cur,
    input  logic [NUM_SRC-1:0]      prev,
    input  chan_cfg_t [NUM_SRC-1:0] chan_cfg,
    input  logic [NUM_SRC-1:0]      clr_mask,
    output logic [NUM_SRC-1:0]      raw
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_ch
        logic act_now;
        logic act_prev;
        logic edge_hit;
        logic latch_q;

        assign act_now  = active_level(chan_cfg[i].pol_high, cur[i]);
        assign act_prev = active_level(chan_cfg[i].pol_high, prev[i]);
        assign edge_hit = chan_cfg[i].edge_sel & act_now & ~act_prev;

        // A fresh transition outranks a clear in the same cycle
        always_ff @(posedge clk) begin
            if (rst)
                latch_q <= 1'b0;
            else if (edge_hit)
                latch_q <= 1'b1;
            else if (clr_mask[i])
                latch_q <= 1'b0;
        end

        assign raw[i] = chan_cfg[i].edge_sel ? latch_q : act_now;
    end
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
    parameter int NUM_SRC = 16,
    parameter int VEC_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] req,
    output logic [VEC_W-1:0]   idx,
    output logic               any
);
    always_comb begin
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) idx = VEC_W'(i);
        end
    end

    assign any = |req;
endmodule

// File: rtl/pol_edge_intc.sv
module pol_edge_intc
    import intc_pkg::*;
#(
    parameter int NUM_SRC     = 16,
    parameter int NUM_EDGE    = 6,
    parameter int NUM_POLONLY = 3,
    parameter int DATA_W      = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_SRC-1:0]         src_in,
    input  logic                       bus_wr,
    input  logic [REG_AW-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       irq_o,
    output logic                       fiq_o,
    output logic [$clog2(NUM_SRC)-1:0] irq_vec,
    output logic                       irq_vec_valid
);
    localparam int VEC_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] sync_cur;
    logic [NUM_SRC-1:0] sync_prev;
    logic [NUM_SRC-1:0] raw_pend;
    logic [NUM_SRC-1:0] clr_mask;
    logic [NUM_SRC-1:0] irq_en;
    logic [NUM_SRC-1:0] fiq_en;
    logic [NUM_SRC-1:0] irq_stat;
    logic [NUM_SRC-1:0] fiq_stat;
    chan_cfg_t [NUM_SRC-1:0] chan_cfg;

    intc_sync #(.W(NUM_SRC)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (src_in),
        .cur      (sync_cur),
        .prev     (sync_prev)
    );

    intc_regs #(
        .NUM_SRC     (NUM_SRC),
        .NUM_EDGE    (NUM_EDGE),
        .NUM_POLONLY (NUM_POLONLY),
        .DATA_W      (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .raw      (raw_pend),
        .irq_stat (irq_stat),
        .fiq_stat (fiq_stat),
        .rdata    (bus_rdata),
        .chan_cfg (chan_cfg),
        .clr_mask (clr_mask),
        .irq_en   (irq_en),
        .fiq_en   (fiq_en)
    );

    intc_pending #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .cur      (sync_cur),
        .prev     (sync_prev),
        .chan_cfg (chan_cfg),
        .clr_mask (clr_mask),
        .raw      (raw_pend)
    );

    assign irq_stat = raw_pend & irq_en;
    assign fiq_stat = raw_pend & fiq_en;
    assign irq_o    = |irq_stat;
    assign fiq_o    = |fiq_stat;

    intc_prio #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_prio (
        .req (irq_stat),
        .idx (irq_vec),
        .any (irq_vec_valid)
    );
endmodule

// File: rtl/pol_edge_intc_chk.sv
module pol_edge_intc_chk #(
    parameter int NUM_SRC = 16,
    parameter int VEC_W   = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst,
    input logic               irq_o,
    input logic               fiq_o,
    input logic [VEC_W-1:0]   vec,
    input logic               vec_valid,
    input logic [NUM_SRC-1:0] raw,
    input logic [NUM_SRC-1:0] irq_en,
    input logic [NUM_SRC-1:0] fiq_en
);
    logic [NUM_SRC-1:0] below;

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) below[i] = (i < int'(vec));
    end

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (irq_en == '0 && fiq_en == '0 && !irq_o && !fiq_o && !vec_valid));

    p_irq_line_r8: assert property (@(posedge clk) disable iff (rst)
        irq_o == ((raw & irq_en) != '0));

    p_fiq_line_r8: assert property (@(posedge clk) disable iff (rst)
        fiq_o == ((raw & fiq_en) != '0));

    p_vec_valid_r9: assert property (@(posedge clk) disable iff (rst)
        vec_valid == irq_o);

    p_vec_hit_r9: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (raw[vec] && irq_en[vec]));

    p_vec_lowest_r9: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> ((raw & irq_en & below) == '0));

    p_vec_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !vec_valid |-> (vec == '0));
endmodule

bind pol_edge_intc pol_edge_intc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .vec       (irq_vec),
    .vec_valid (irq_vec_valid),
    .raw       (raw_pend),
    .irq_en    (irq_en),
    .fiq_en    (fiq_en)
);

// File: tb/pol_edge_intc_test.sv
module pol_edge_intc_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] src;
    logic        bus_wr;
    logic [2:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        irq_o, fiq_o, irq_vec_valid;
    logic [3:0]  irq_vec;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference state
    logic [15:0] m_s1, m_s2, m_s3, m_lat, m_ien, m_fen;
    logic [11:0] m_cfga;
    logic [2:0]  m_cfgb;

    always #4 clk = ~clk;

    pol_edge_intc uut (
        .clk(clk), .rst(rst), .src_in(src), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o),
        .irq_vec(irq_vec), .irq_vec_valid(irq_vec_valid)
    );

    function automatic logic mpol(int i);
        if (i < 6) return m_cfga[2*i];
        if (i < 9) return m_cfgb[i-6];
        return 1'b1;
    endfunction

    function automatic logic medge(int i);
        return (i < 6) ? m_cfga[2*i+1] : 1'b0;
    endfunction

    function automatic logic [15:0] m_raw();
        logic [15:0] r;
        for (int i = 0; i < 16; i++) begin
            logic a;
            a = mpol(i) ? m_s2[i] : ~m_s2[i];
            r[i] = medge(i) ? m_lat[i] : a;
        end
        return r;
    endfunction

    function automatic logic [15:0] m_read(logic [2:0] a);
        case (a)
            3'd0: return {4'h0, m_cfga};
            3'd1: return {13'h0, m_cfgb};
            3'd3: return m_ien;
            3'd4: return m_fen;
            3'd5: return m_raw();
            3'd6: return m_raw() & m_ien;
            3'd7: return m_raw() & m_fen;
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic [3:0] m_low(logic [15:0] v);
        logic [3:0] k = 4'd0;
        for (int i = 15; i >= 0; i--) if (v[i]) k = 4'(i);
        return k;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_s3 = '0; m_lat = '0;
            m_ien = '0; m_fen = '0; m_cfga = '0; m_cfgb = '0;
        end else begin
            logic [15:0] nl;
            for (int i = 0; i < 16; i++) begin
                logic an, ap, hit, cl;
                an  = mpol(i) ? m_s2[i] : ~m_s2[i];
                ap  = mpol(i) ? m_s3[i] : ~m_s3[i];
                hit = medge(i) & an & ~ap;
                cl  = bus_wr && bus_addr == 3'd2 && bus_wdata[i];
                nl[i] = hit ? 1'b1 : (cl ? 1'b0 : m_lat[i]);
            end
            m_lat = nl;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = src;
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: m_cfga = bus_wdata[11:0];
                    3'd1: m_cfgb = bus_wdata[2:0];
                    3'd3: m_ien  = bus_wdata;
                    3'd4: m_fen  = bus_wdata;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        if (!rst) begin
            logic [15:0] is, fs;
            is = m_raw() & m_ien;
            fs = m_raw() & m_fen;
            chk("R8 irq line", irq_o, |is);
            chk("R8 fiq line", fiq_o, |fs);
            chk("R9 vector valid", irq_vec_valid, |is);
            chk("R9 vector", irq_vec, m_low(is));
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, string tag);
        bus_addr = a; #1;
        chk(tag, bus_rdata, m_read(a));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; src = 16'h01FF; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        #1;
        // R1: quiet state right after reset
        chk("R1 irq_o", irq_o, 0);
        chk("R1 fiq_o", fiq_o, 0);
        chk("R1 vec_valid", irq_vec_valid, 0);
        chk("R1 vec", irq_vec, 0);
        bus_addr = 3'd0; #1; chk("R1 cfgA", bus_rdata, 0);
        bus_addr = 3'd3; #1; chk("R1 irq enable", bus_rdata, 0);
        repeat (3) tick();

        // R5: field width of word A
        wr(3'd0, 16'hFFFF);
        bus_addr = 3'd0; #1; chk("R5 cfgA readback", bus_rdata, 16'h0FFF);
        // ch0 rising edge, ch1 falling edge, others level
        wr(3'd0, 16'h000B);
        wr(3'd3, 16'hFFFF);
        repeat (3) tick();
        wr(3'd2, 16'hFFFF);
        src[0] = 1'b0; repeat (3) tick();
        bus_addr = 3'd5; #1; chk("R3 no latch on inactive edge", bus_rdata[0], 0);
        src[0] = 1'b1; tick(); tick();
        bus_addr = 3'd5; #1; chk("R3 latency not yet", bus_rdata[0], 0);
        tick();
        bus_addr = 3'd5; #1; chk("R3 rising latched", bus_rdata[0], 1);
        src[0] = 1'b0; repeat (3) tick();
        rd(3'd5, "R3 hold after return");
        chk("R3 hold bit", bus_rdata[0], 1);
        chk("R9 vector ch0", irq_vec, 0);
        wr(3'd2, 16'hFFFE);
        rd(3'd5, "R4 zero bits no effect");
        chk("R4 latch kept", bus_rdata[0], 1);
        wr(3'd2, 16'h0001);
        bus_addr = 3'd5; #1; chk("R4 cleared", bus_rdata[0], 0);
        src[1] = 1'b0; repeat (3) tick();
        bus_addr = 3'd5; #1; chk("R3 falling latched", bus_rdata[1], 1);
        chk("R9 vector ch1", irq_vec, 4'd1);
        wr(3'd2, 16'h0002);
        // R4: set and clear in the same cycle
        src[0] = 1'b1; tick(); tick();
        wr(3'd2, 16'h0001);
        bus_addr = 3'd5; #1; chk("R4 set wins over clear", bus_rdata[0], 1);
        wr(3'd2, 16'h0001);
        rd(3'd5, "R4 clear after");

        // R2: ch2 active-high level
        wr(3'd0, 16'h001B);
        src[2] = 1'b0; repeat (3) tick();
        src[2] = 1'b1; tick();
        bus_addr = 3'd5; #1; chk("R2 one cycle not yet", bus_rdata[2], 0);
        tick();
        bus_addr = 3'd5; #1; chk("R2 level follows", bus_rdata[2], 1);
        wr(3'd2, 16'h0004);
        bus_addr = 3'd5; #1; chk("R2 clear ignored", bus_rdata[2], 1);
        src[2] = 1'b0; tick(); tick();
        rd(3'd5, "R2 level drops");

        // R6: word B and fixed channels
        wr(3'd1, 16'hFFFF);
        bus_addr = 3'd1; #1; chk("R6 cfgB readback", bus_rdata, 16'h0007);
        wr(3'd1, 16'h0002);
        src[12] = 1'b1; tick(); tick();
        bus_addr = 3'd5; #1;
        chk("R6 ch7 active high", bus_rdata[7], 1);
        chk("R6 ch6 active low idle", bus_rdata[6], 0);
        chk("R6 ch12 fixed high", bus_rdata[12], 1);

        // R7: separate enables
        wr(3'd3, 16'h0000);
        wr(3'd4, 16'h1080);
        rd(3'd7, "R7 fast status");
        rd(3'd6, "R7 normal status masked");
        rd(3'd5, "R7 raw ungated");
        chk("R7 fiq_o", fiq_o, 1);
        chk("R7 irq_o off", irq_o, 0);

        // R10: ignored writes and clear readback
        wr(3'd5, 16'h0000);
        wr(3'd6, 16'hFFFF);
        wr(3'd7, 16'hFFFF);
        for (int a = 0; a < 8; a++) rd(3'(a), "R10 readback");

        // random phase
        for (int n = 0; n < 1500; n++) begin
            src = src ^ (16'($urandom) & 16'($urandom) & 16'($urandom));
            if ($urandom_range(0, 5) == 0) begin
                bus_wr = 1'b1;
                bus_addr = 3'($urandom_range(0, 7));
                bus_wdata = 16'($urandom);
            end else begin
                bus_wr = 1'b0;
                bus_addr = 3'($urandom_range(0, 7));
            end
            #1;
            chk("R10 R7 random read", bus_rdata, m_read(bus_addr));
            tick();
            bus_wr = 1'b0;
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule